// File: doc/BRIEF.md
# Layer Framebuffer Fetch Address Generator

This block walks the framebuffer window of one display layer and issues the memory read requests that fetch it. For each request it gives a byte address and a length in bytes. A frame starts on a single-cycle start pulse. The block then covers the window one line at a time. The first line begins at the base address. Each later line begins one stride further on, and the stride is a byte count that is independent of the visible width. A stride wider than the line skips padding, and a base offset into a larger image gives panning and clipping. Each line is cut into bursts. A burst is at most 16 beats long when long bursts are enabled and at most 4 beats otherwise. A burst never runs past the end of a line.

The pixel format sets how many bytes a line occupies. Plain formats use a whole number of bytes per pixel. Compressed formats store 4x4 pixel tiles of fixed size, so each fetched row covers four display lines. The layer settings pass through a shadow stage. With protection off, the shadow follows the inputs. With protection on, the shadow takes new values only at the end of a frame, so software can rewrite the settings while a frame is running without tearing it.

Top module: `lyr_fetch_addrgen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `req_valid` and `frame_done` are low.
- R2: The first request of a frame carries the base address. The requests within one fetched row follow each other at consecutive byte addresses, so each one starts where the previous one ended.
- R3: Fetched row n (counting from 0) starts at base + n × stride, computed modulo 2^32. The stride is used whatever the row length is, and it may be smaller or larger than the row.
- R4: For the plain formats, a row has xsize × bytes-per-pixel bytes. The `cfg_fmt` codes are 0 = 4 bytes, 1 = 3 bytes, 2 = 2 bytes and 3 = 1 byte per pixel. Code 7 is treated as 1 byte per pixel. There are ysize rows.
- R5: For the tiled formats, `cfg_fmt` code 4 has 8 bytes per tile, and codes 5 and 6 have 12 bytes per tile. A fetched row has ceil(xsize/4) tiles, and there are ceil(ysize/4) rows.
- R6: A request is at most 64 bytes long when `cfg_long_burst` is 1 and at most 16 bytes when it is 0. A row is split into full-size requests, and the last request of the row is shortened to the bytes that remain. No request spans two rows.
- R7: While `req_valid` is high and `req_ready` is low, the request stays valid and its address and length do not change.
- R8: `frame_done` is high for exactly one cycle, in the cycle right after the final request of the frame is accepted. It never coincides with `req_valid`.
- R9: If xsize or ysize is 0, a frame start issues no request. `frame_done` pulses in the cycle after the start pulse is sampled.
- R10: A `frame_start` pulse that arrives while a frame is in progress is ignored. It neither restarts nor adds requests.
- R11: With `cfg_protect` low, settings that are steady for at least one clock edge before the edge that samples `frame_start` are the ones used for that frame. A frame's settings are fixed when it starts.
- R12: With `cfg_protect` high, the settings used are those held at the most recent frame end, or before protection was raised. New input values are adopted at the clock edge that ends the `frame_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Byte address of the first row |
| cfg_stride | input | 16 | Byte distance between starts of consecutive fetched rows |
| cfg_xsize | input | 16 | Window width in pixels |
| cfg_ysize | input | 16 | Window height in lines |
| cfg_fmt | input | 3 | Pixel format code (see R4, R5) |
| cfg_long_burst | input | 1 | 1 allows 16-beat bursts, 0 limits bursts to 4 beats |
| cfg_protect | input | 1 | 1 makes settings change only at frame end |
| frame_start | input | 1 | Single-cycle pulse that starts a frame |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high together with req_valid |
| req_addr | output | 32 | Request byte address |
| req_len | output | 7 | Request length in bytes (1 to 64) |
| frame_done | output | 1 | One-cycle pulse after the last request of a frame |

## Verification
A wrong remaining-byte count shows up in the length of the very next request. A wrong row pointer shows up in the address of the first request of the next row. So most faults in the walking logic reach the port within one handshake. A shadow stage that commits at the wrong time stays hidden until the next frame starts, and then its first request carries the old or the new base address. A wrong row counter shows up as either a missing or an extra row at the end of the frame, together with a `frame_done` pulse that is late or early.

// File: rtl/lyr_pkg.sv
package lyr_pkg;

  localparam int BLK_DIM   = 4;
  localparam int BLK_SHIFT = 2;

  typedef enum logic [2:0] {
    PF_W32   = 3'd0,
    PF_RGB24 = 3'd1,
    PF_W16   = 3'd2,
    PF_W8    = 3'd3,
    PF_BLK4  = 3'd4,
    PF_BLK6  = 3'd5,
    PF_BLK6A = 3'd6,
    PF_RSVD  = 3'd7
  } pix_fmt_e;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } wk_state_e;

  // Bytes per pixel for plain formats, bytes per 4x4 tile for tiled ones
  function automatic logic [3:0] unit_bytes(input logic [2:0] f);
    case (pix_fmt_e'(f))
      PF_W32:   return 4'd4;
      PF_RGB24: return 4'd3;
      PF_W16:   return 4'd2;
      PF_W8:    return 4'd1;
      PF_BLK4:  return 4'd8;
      PF_BLK6:  return 4'd12;
      PF_BLK6A: return 4'd12;
      default:  return 4'd1;
    endcase
  endfunction

  function automatic logic is_tiled(input logic [2:0] f);
    return (f == PF_BLK4) || (f == PF_BLK6) || (f == PF_BLK6A);
  endfunction

endpackage

// File: rtl/lyr_cfg_shadow.sv
module lyr_cfg_shadow #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int SIZE_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                protect,
  input  logic                commit,
  input  logic [ADDR_W-1:0]   live_base,
  input  logic [STRIDE_W-1:0] live_stride,
  input  logic [SIZE_W-1:0]   live_xsize,
  input  logic [SIZE_W-1:0]   live_ysize,
  input  logic [2:0]          live_fmt,
  input  logic                live_long,
  output logic [ADDR_W-1:0]   sh_base,
  output logic [STRIDE_W-1:0] sh_stride,
  output logic [SIZE_W-1:0]   sh_xsize,
  output logic [SIZE_W-1:0]   sh_ysize,
  output logic [2:0]          sh_fmt,
  output logic                sh_long
);

  logic take;
  assign take = !protect || commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_base   <= '0;
      sh_stride <= '0;
      sh_xsize  <= '0;
      sh_ysize  <= '0;
      sh_fmt    <= '0;
      sh_long   <= 1'b0;
    end else if (take) begin
      sh_base   <= live_base;
      sh_stride <= live_stride;
      sh_xsize  <= live_xsize;
      sh_ysize  <= live_ysize;
      sh_fmt    <= live_fmt;
      sh_long   <= live_long;
    end
  end

  // R12
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (protect && !commit) |=> ($stable(sh_base) && $stable(sh_stride) &&
                              $stable(sh_xsize) && $stable(sh_ysize) &&
                              $stable(sh_fmt) && $stable(sh_long)));

endmodule

// File: rtl/lyr_line_geom.sv
module lyr_line_geom
  import lyr_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int LB_W   = SIZE_W + 4
) (
  input  logic [SIZE_W-1:0] xsize,
  input  logic [SIZE_W-1:0] ysize,
  input  logic [2:0]        fmt,
  output logic [LB_W-1:0]   row_bytes,
  output logic [SIZE_W-1:0] rows
);

  logic [SIZE_W:0]   x_up, y_up;
  logic [SIZE_W-1:0] units;
  logic [3:0]        ub;
  logic              tiled;

  always_comb begin
    ub    = unit_bytes(fmt);
    tiled = is_tiled(fmt);
    x_up  = (SIZE_W+1)'(xsize) + (SIZE_W+1)'(BLK_DIM - 1);
    y_up  = (SIZE_W+1)'(ysize) + (SIZE_W+1)'(BLK_DIM - 1);
    units = tiled ? SIZE_W'(x_up >> BLK_SHIFT) : xsize;
    rows  = tiled ? SIZE_W'(y_up >> BLK_SHIFT) : ysize;
    row_bytes = LB_W'(units) * LB_W'(ub);
  end

endmodule

// File: rtl/lyr_burst_walker.sv
module lyr_burst_walker
  import lyr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int STRIDE_W    = 16,
  parameter int SIZE_W      = 16,
  parameter int LB_W        = SIZE_W + 4,
  parameter int LONG_BYTES  = 64,
  parameter int SHORT_BYTES = 16,
  parameter int LEN_W       = $clog2(LONG_BYTES) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_start,
  input  logic [ADDR_W-1:0]   base,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                long_burst,
  input  logic [LB_W-1:0]     row_bytes,
  input  logic [SIZE_W-1:0]   rows,
  input  logic                req_ready,
  output logic                req_valid,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [LEN_W-1:0]    req_len,
  output logic                frame_done
);

  wk_state_e           state;
  logic [ADDR_W-1:0]   row_addr;
  logic [STRIDE_W-1:0] stride_q;
  logic [LB_W-1:0]     row_bytes_q;
  logic [LB_W-1:0]     rem;
  logic [SIZE_W-1:0]   rows_left;
  logic [LEN_W-1:0]    maxb_q;
  logic [LEN_W-1:0]    maxb_new;
  logic [ADDR_W-1:0]   next_row;

  function automatic logic [LEN_W-1:0] clip(input logic [LB_W-1:0] v,
                                            input logic [LEN_W-1:0] m);
    if (v > LB_W'(m)) return m;
    return LEN_W'(v);
  endfunction

  assign maxb_new = long_burst ? LEN_W'(LONG_BYTES) : LEN_W'(SHORT_BYTES);
  assign next_row = row_addr + ADDR_W'(stride_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WK_IDLE;
      req_valid   <= 1'b0;
      req_addr    <= '0;
      req_len     <= '0;
      frame_done  <= 1'b0;
      row_addr    <= '0;
      stride_q    <= '0;
      row_bytes_q <= '0;
      rem         <= '0;
      rows_left   <= '0;
      maxb_q      <= '0;
    end else begin
      frame_done <= 1'b0;
      case (state)
        WK_IDLE: begin
          if (frame_start) begin
            stride_q    <= stride;
            row_bytes_q <= row_bytes;
            maxb_q      <= maxb_new;
            if (row_bytes == '0 || rows == '0) begin
              frame_done <= 1'b1;
            end else begin
              req_addr  <= base;
              row_addr  <= base;
              rem       <= row_bytes;
              rows_left <= rows;
              req_len   <= clip(row_bytes, maxb_new);
              req_valid <= 1'b1;
              state     <= WK_RUN;
            end
          end
        end
        WK_RUN: begin
          if (req_ready) begin
            if (rem > LB_W'(maxb_q)) begin
              req_addr <= req_addr + ADDR_W'(maxb_q);
              rem      <= rem - LB_W'(maxb_q);
              req_len  <= clip(rem - LB_W'(maxb_q), maxb_q);
            end else if (rows_left == SIZE_W'(1)) begin
              req_valid  <= 1'b0;
              frame_done <= 1'b1;
              state      <= WK_IDLE;
            end else begin
              row_addr  <= next_row;
              req_addr  <= next_row;
              rem       <= row_bytes_q;
              rows_left <= rows_left - SIZE_W'(1);
              req_len   <= clip(row_bytes_q, maxb_q);
            end
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0 && req_len <= LEN_W'(LONG_BYTES)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !req_valid);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && frame_start) |=> $stable(req_addr));

endmodule

// File: rtl/lyr_fetch_addrgen.sv
module lyr_fetch_addrgen #(
  parameter int ADDR_W      = 32,
  parameter int STRIDE_W    = 16,
  parameter int SIZE_W      = 16,
  parameter int BEAT_BYTES  = 4,
  parameter int LONG_BEATS  = 16,
  parameter int SHORT_BEATS = 4,
  localparam int LONG_BYTES  = BEAT_BYTES * LONG_BEATS,
  localparam int SHORT_BYTES = BEAT_BYTES * SHORT_BEATS,
  localparam int LEN_W       = $clog2(LONG_BYTES) + 1,
  localparam int LB_W        = SIZE_W + 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [SIZE_W-1:0]   cfg_xsize,
  input  logic [SIZE_W-1:0]   cfg_ysize,
  input  logic [2:0]          cfg_fmt,
  input  logic                cfg_long_burst,
  input  logic                cfg_protect,
  input  logic                frame_start,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [LEN_W-1:0]    req_len,
  output logic                frame_done
);

  logic [ADDR_W-1:0]   sh_base;
  logic [STRIDE_W-1:0] sh_stride;
  logic [SIZE_W-1:0]   sh_xsize, sh_ysize;
  logic [2:0]          sh_fmt;
  logic                sh_long;
  logic [LB_W-1:0]     row_bytes;
  logic [SIZE_W-1:0]   rows;

  lyr_cfg_shadow #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .SIZE_W(SIZE_W)
  ) shadow_i (
    .clk(clk), .rst(rst), .protect(cfg_protect), .commit(frame_done),
    .live_base(cfg_base), .live_stride(cfg_stride), .live_xsize(cfg_xsize),
    .live_ysize(cfg_ysize), .live_fmt(cfg_fmt), .live_long(cfg_long_burst),
    .sh_base(sh_base), .sh_stride(sh_stride), .sh_xsize(sh_xsize),
    .sh_ysize(sh_ysize), .sh_fmt(sh_fmt), .sh_long(sh_long)
  );

  lyr_line_geom #(
    .SIZE_W(SIZE_W), .LB_W(LB_W)
  ) geom_i (
    .xsize(sh_xsize), .ysize(sh_ysize), .fmt(sh_fmt),
    .row_bytes(row_bytes), .rows(rows)
  );

  lyr_burst_walker #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .SIZE_W(SIZE_W), .LB_W(LB_W),
    .LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES), .LEN_W(LEN_W)
  ) walker_i (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .base(sh_base), .stride(sh_stride), .long_burst(sh_long),
    .row_bytes(row_bytes), .rows(rows),
    .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .frame_done(frame_done)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!req_valid && !frame_done));

endmodule

// File: tb/lyr_fetch_addrgen_tb_top.sv
`timescale 1ns/100ps
module lyr_fetch_addrgen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_stride = '0, cfg_xsize = '0, cfg_ysize = '0;
  logic [2:0]  cfg_fmt = '0;
  logic        cfg_long_burst = 1'b0, cfg_protect = 1'b0;
  logic        frame_start = 1'b0;
  logic        req_valid, req_ready = 1'b0, frame_done;
  logic [31:0] req_addr;
  logic [6:0]  req_len;

  always #2 clk = ~clk;

  lyr_fetch_addrgen dut_i (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
    .cfg_xsize(cfg_xsize), .cfg_ysize(cfg_ysize), .cfg_fmt(cfg_fmt),
    .cfg_long_burst(cfg_long_burst), .cfg_protect(cfg_protect),
    .frame_start(frame_start), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .frame_done(frame_done)
  );

  typedef struct {
    logic [31:0] addr;
    int          len;
    bit          last;
    string       tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0, n_fail = 0, done_cnt = 0, cycles = 0;
  bit    pend_done = 0, zero_pend = 0, prev_stall = 0, tog = 0;
  int    rdy_mode = 0;
  logic [7:0]  lf = 8'h5A;
  logic [31:0] prev_addr = '0;
  logic [6:0]  prev_len = '0;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // Monitor: samples at the falling edge, decides ready for the next rising edge
  always @(negedge clk) begin
    if (!rst) begin
      bit rdy;
      exp_t e;
      if (zero_pend) begin
        chk(frame_done == 1'b1, "R9", "frame_done after empty frame", frame_done, 1);
        chk(req_valid == 1'b0, "R9", "no request on empty frame", req_valid, 0);
        zero_pend = 0;
        done_cnt++;
      end else if (pend_done) begin
        chk(frame_done == 1'b1, "R8", "frame_done after last request", frame_done, 1);
        pend_done = 0;
        done_cnt++;
      end else if (frame_done) begin
        chk(1'b0, "R8", "unexpected frame_done", 1, 0);
      end
      if (prev_stall) begin
        chk(req_valid && req_addr == prev_addr && req_len == prev_len, "R7",
            "held request", {req_valid, req_addr, req_len}, {1'b1, prev_addr, prev_len});
      end
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tog = !tog;
      case (rdy_mode)
        0:       rdy = 1'b1;
        1:       rdy = tog;
        default: rdy = lf[0] | lf[1];
      endcase
      req_ready = rdy;
      if (req_valid && rdy) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R10", "request with nothing expected", req_addr, 0);
        end else begin
          e = sb_q.pop_front();
          chk(req_addr == e.addr, e.tag, "request address", req_addr, e.addr);
          chk(int'(req_len) == e.len, e.tag, "request length", req_len, e.len);
          if (e.last) pend_done = 1;
        end
      end
      prev_stall = req_valid && !rdy;
      prev_addr  = req_addr;
      prev_len   = req_len;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R8 no frame end): actual %0d cycles expected < 150000", cycles);
      summary();
      $finish;
    end
  end

  // Driver side: the expected model pushes bursts into the scoreboard
  function automatic bit push_frame(input logic [31:0] b, input int s, input int x,
                                    input int y, input int f, input bit l16);
    int unit, units, rows, rb, mb;
    bit tiled;
    tiled = (f >= 4 && f <= 6);
    case (f)
      0: unit = 4; 1: unit = 3; 2: unit = 2; 3: unit = 1;
      4: unit = 8; 5: unit = 12; 6: unit = 12;
      default: unit = 1;
    endcase
    units = tiled ? (x + 3) / 4 : x;
    rows  = tiled ? (y + 3) / 4 : y;
    rb    = units * unit;
    mb    = l16 ? 64 : 16;
    if (rb == 0 || rows == 0) return 1'b1;
    for (int r = 0; r < rows; r++) begin
      logic [31:0] a;
      int rem;
      a = b + 32'(r * s);
      rem = rb;
      while (rem > 0) begin
        exp_t e;
        e.len  = (rem > mb) ? mb : rem;
        e.addr = a;
        e.last = (r == rows - 1) && (rem == e.len);
        e.tag  = cur_tag;
        sb_q.push_back(e);
        a   = a + 32'(e.len);
        rem = rem - e.len;
      end
    end
    return 1'b0;
  endfunction

  task automatic set_cfg(input logic [31:0] b, input int s, input int x,
                         input int y, input int f, input bit l16);
    @(negedge clk); #1;
    cfg_base = b; cfg_stride = 16'(s); cfg_xsize = 16'(x);
    cfg_ysize = 16'(y); cfg_fmt = 3'(f); cfg_long_burst = l16;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_frame(input bit z);
    @(negedge clk); #1;
    frame_start = 1'b1;
    zero_pend = z;
    @(negedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic go(input string tag, input logic [31:0] b, input int s, input int x,
                    input int y, input int f, input bit l16);
    int old;
    bit z;
    cur_tag = tag;
    z = push_frame(b, s, x, y, f, l16);
    old = done_cnt;
    start_frame(z);
    while (done_cnt == old) @(negedge clk);
    chk(sb_q.size() == 0, tag, "all expected requests seen", sb_q.size(), 0);
  endtask

  task automatic run(input string tag, input logic [31:0] b, input int s, input int x,
                     input int y, input int f, input bit l16);
    set_cfg(b, s, x, y, f, l16);
    go(tag, b, s, x, y, f, l16);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!req_valid && !frame_done, "R1", "outputs in reset", {req_valid, frame_done}, 0);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!req_valid && !frame_done, "R1", "outputs after reset", {req_valid, frame_done}, 0);

    // R2 R3 R4: 32-bit pixels, padded stride, one burst per row
    rdy_mode = 0;
    run("R3", 32'h0000_1000, 64, 10, 3, 0, 1'b1);
    // R6: 3-byte pixels, short bursts split and last shortened
    rdy_mode = 1;
    run("R6", 32'h0002_0000, 100, 30, 2, 1, 1'b0);
    // R6: 16-bit pixels, long bursts 64 + 36
    rdy_mode = 2;
    run("R6", 32'h0003_0010, 200, 50, 2, 2, 1'b1);
    // R4: 8-bit pixels and reserved code 7
    run("R4", 32'h0000_0100, 16, 7, 4, 3, 1'b0);
    run("R4", 32'h0000_0200, 16, 7, 2, 7, 1'b1);
    // R5: tiled formats
    run("R5", 32'h0004_0000, 32, 10, 9, 4, 1'b1);
    run("R5", 32'h0004_8000, 48, 8, 4, 5, 1'b1);
    run("R5", 32'h0005_0000, 80, 17, 5, 6, 1'b0);
    // R3: stride smaller than the row, address wraps at 2^32
    rdy_mode = 1;
    run("R3", 32'hFFFF_FFF0, 8, 4, 3, 0, 1'b0);
    // R2: long row with long bursts, consecutive addresses
    rdy_mode = 0;
    run("R2", 32'h0006_0000, 1024, 200, 2, 0, 1'b1);
    // R9: empty windows
    run("R9", 32'h0000_0000, 16, 0, 5, 0, 1'b1);
    run("R9", 32'h0000_0000, 16, 5, 0, 2, 1'b1);

    // R10: second start pulse in the middle of a running frame
    rdy_mode = 2;
    set_cfg(32'h0007_0000, 512, 128, 6, 2, 1'b0);
    begin
      int old;
      bit z;
      cur_tag = "R10";
      z = push_frame(32'h0007_0000, 512, 128, 6, 2, 1'b0);
      old = done_cnt;
      start_frame(z);
      repeat (6) @(negedge clk);
      #1 frame_start = 1'b1;
      @(negedge clk); #1 frame_start = 1'b0;
      while (done_cnt == old) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        chk(!req_valid && sb_q.size() == 0, "R10", "idle after frame", req_valid, 0);
      end
    end

    // R11 R12: protection holds settings until a frame end
    rdy_mode = 0;
    cfg_protect = 1'b0;
    run("R11", 32'h0008_0000, 64, 8, 2, 0, 1'b1);
    @(negedge clk); #1 cfg_protect = 1'b1;
    set_cfg(32'h0009_0000, 96, 12, 3, 2, 1'b0);
    go("R12", 32'h0008_0000, 64, 8, 2, 0, 1'b1);
    set_cfg(32'h000A_0000, 40, 5, 2, 3, 1'b1);
    go("R12", 32'h0009_0000, 96, 12, 3, 2, 1'b0);
    @(negedge clk); #1 cfg_protect = 1'b0;
    set_cfg(32'h000B_0000, 40, 6, 2, 3, 1'b1);
    go("R11", 32'h000B_0000, 40, 6, 2, 3, 1'b1);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule